// File: doc/BRIEF.md
# MSI request capture handshake

This block takes message-signalled interrupt requests from user logic on the bridge side and hands them, one at a time, to a downstream interrupt port. The request strobe and the vector number first pass together through a one-cycle register stage. A rising edge of the registered strobe, seen while the block is idle, captures the registered vector and starts a handshake.

During the handshake the block holds a valid signal high and presents the captured vector on its output. It ignores every change on the request strobe and the vector input until the downstream port signals ready. It then returns to idle and pulses a grant back to the user logic for one cycle.

Because the inputs are delayed before use, user logic may raise its next request, with a new vector, in the same cycle that the grant is high. That request is captured normally. A request only needs to be high for one cycle. It must be low again before the handshake ends, or it is not seen as a new edge.

Top module: `msi_req_capture`

## Requirements
- R1: A synchronous active-high reset clears the delay stage and returns the block to idle. On the first cycle after a reset edge, irq_valid_o and grant_o are both 0, and any grant that was pending is dropped.
- R2: Suppose req_i is 1 for the first time before edge N, after being 0 before edge N-1, and the block is idle. Then irq_valid_o is 1 after edge N+1, and irq_vec_o equals the vec_i value that was sampled at edge N.
- R3: The vector is sampled only in the cycle of the delayed request's rising edge. A change on vec_i in any later cycle does not alter irq_vec_o.
- R4: While irq_valid_o is 1 and irq_ready_i is 0, irq_valid_o stays 1 and irq_vec_o keeps its value, whatever req_i and vec_i do.
- R5: irq_valid_o falls only on an edge at which irq_ready_i is 1. The block then goes idle after that edge.
- R6: grant_o is 1 for exactly the one cycle after the edge that ends the handshake. At all other times it is 0.
- R7: A new request with a new vector, driven during the cycle in which grant_o is 1, is captured and appears on irq_vec_o two edges later.
- R8: A request held high continuously starts only one handshake. A request that rises and falls during a handshake starts none.
- R9: The vector width is the parameter VEC_W, default 5, which covers 32 vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Interrupt request strobe from user logic |
| vec_i | input | VEC_W | Vector number accompanying the request |
| irq_ready_i | input | 1 | Downstream port has accepted the interrupt |
| irq_valid_o | output | 1 | Handshake in progress; irq_vec_o is valid |
| irq_vec_o | output | VEC_W | Captured vector number |
| grant_o | output | 1 | One-cycle pulse when the handshake completes |

## Verification
The assertions assume that irq_ready_i is meaningful only while irq_valid_o is high. They also assume that user logic drops req_i before it expects the next handshake to start, because a request still high when the handshake ends gives no new edge. The bench raises irq_ready_i only while valid is high and clears it right after the completing edge. Its requests last one cycle, except in the held-high and in-handshake toggling tests, which are made to show the ignore behaviour. Inputs change only after a clock edge, so the two-cycle latency from request to valid is exact.

// File: rtl/msi_req_capture.sv
module msi_req_capture #(
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             irq_ready_i,
  output logic             irq_valid_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             grant_o
);

  logic             req_d, req_d2;
  logic [VEC_W-1:0] vec_d;
  logic             busy;
  logic [VEC_W-1:0] vec_hold;
  logic             grant_q;
  logic             rise;

  assign rise        = req_d & ~req_d2;
  assign irq_valid_o = busy;
  assign irq_vec_o   = vec_hold;
  assign grant_o     = grant_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d    <= 1'b0;
      req_d2   <= 1'b0;
      vec_d    <= '0;
      busy     <= 1'b0;
      vec_hold <= '0;
      grant_q  <= 1'b0;
    end else begin
      req_d   <= req_i;
      req_d2  <= req_d;
      vec_d   <= vec_i;
      grant_q <= busy & irq_ready_i;
      if (!busy) begin
        if (rise) begin
          busy     <= 1'b1;
          vec_hold <= vec_d;
        end
      end else if (irq_ready_i) begin
        busy <= 1'b0;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!irq_valid_o && !grant_o));

  p_vec_from_delay_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_valid_o) |-> (irq_vec_o == $past(vec_i, 2)));

  p_hold_in_handshake_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_valid_o && !irq_ready_i) |=> (irq_valid_o && $stable(irq_vec_o)));

  p_exit_on_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_valid_o && irq_ready_i) |=> (!irq_valid_o && grant_o));

  p_grant_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    grant_o |=> !grant_o);

  p_grant_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_o) |-> $past(irq_valid_o && irq_ready_i));

endmodule

// File: tb/msi_req_capture_bench.sv
module msi_req_capture_bench;
  localparam int CLK_P = 10;
  localparam int VW = 5;

  logic clk = 0, rst = 1, req = 0, rdy = 0;
  logic [VW-1:0] vec = '0;
  logic valid, grant;
  logic [VW-1:0] vout;
  int checks = 0, failures = 0;

  always #(CLK_P/2) clk = ~clk;

  msi_req_capture #(.VEC_W(VW)) u_msi_req_capture (
    .clk(clk), .rst(rst), .req_i(req), .vec_i(vec), .irq_ready_i(rdy),
    .irq_valid_o(valid), .irq_vec_o(vout), .grant_o(grant));

  // each entry: vector [8:4], ready delay [3:0]
  localparam logic [8:0] TAB [0:5] = '{
    {5'd0, 4'd0}, {5'd31, 4'd3}, {5'd10, 4'd1},
    {5'd21, 4'd5}, {5'd1, 4'd2}, {5'd16, 4'd0}};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic finish_hs(input string r);
    rdy = 1; step(); rdy = 0;
    chk(r, {30'd0, valid, grant}, 32'b01);
    step();
    chk({r, " R6 pulse"}, {31'd0, grant}, 32'd0);
  endtask

  initial begin
    #(CLK_P * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step();
    rst = 0;
    chk("R1 reset state", {30'd0, valid, grant}, 32'd0);

    // table walk: R2, R3, R5, R6, R9
    for (int i = 0; i < 6; i++) begin
      req = 1; vec = TAB[i][8:4]; step();
      req = 0; vec = ~TAB[i][8:4]; step();
      chk("R2 valid", {31'd0, valid}, 32'd1);
      chk("R3 vector at edge only", {27'd0, vout}, {27'd0, TAB[i][8:4]});
      for (int d = 0; d < int'(TAB[i][3:0]); d++) begin
        step();
        chk("R5 waits for ready", {31'd0, valid}, 32'd1);
      end
      finish_hs("R5 exit and R6 grant");
    end

    // R4: toggles during handshake ignored; R8: in-handshake pulse starts nothing
    req = 1; vec = 5'd7; step();
    req = 0; step();
    req = 1; vec = 5'd25; step();
    req = 0; vec = 5'd3; step();
    chk("R4 vector held", {27'd0, vout}, 32'd7);
    chk("R4 valid held", {31'd0, valid}, 32'd1);
    finish_hs("R4 completion");
    step();
    chk("R8 no extra capture after toggle", {31'd0, valid}, 32'd0);

    // R7: new request in grant cycle
    req = 1; vec = 5'd12; step();
    req = 0; step();
    rdy = 1; step(); rdy = 0;
    chk("R7 grant", {31'd0, grant}, 32'd1);
    req = 1; vec = 5'd29; step();
    req = 0; step();
    chk("R7 recapture valid", {31'd0, valid}, 32'd1);
    chk("R7 recapture vector", {27'd0, vout}, 32'd29);
    finish_hs("R7 completion");

    // R8: held high gives one handshake
    req = 1; vec = 5'd18; step(); step();
    chk("R8 held capture", {27'd0, vout}, 32'd18);
    finish_hs("R8 completion");
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R8 held no repeat", {31'd0, valid}, 32'd0);
    end
    req = 0; step(); step();

    // R1: reset mid-handshake suppresses grant
    req = 1; vec = 5'd9; step();
    req = 0; step();
    chk("R1 setup valid", {31'd0, valid}, 32'd1);
    rst = 1; rdy = 1; step();
    rst = 0; rdy = 0;
    chk("R1 mid reset", {30'd0, valid, grant}, 32'd0);
    step();
    chk("R1 no late grant", {30'd0, valid, grant}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule